// File: doc/BRIEF.md
# UART Diagnostic Loopback Router

This block sits between one UART channel's shift engines and its external pins. It steers the serial data and the flow-control lines according to a 2-bit channel mode. In normal operation the transmitter drives the data-out pin and the receiver listens to the data-in pin. In local loopback the transmitter's serial stream is turned back into the receiver, and the outside world sees an idle line. In remote loopback whatever arrives on data-in is re-timed and echoed back out, and received characters are kept away from the receive FIFO.

Each diagnostic mode does more than switch the data path. It also overrides the transmitter's clear-to-send gating, the receiver's enable, the request-to-send output, and the delivery of characters and error strobes. The remote echo is rebuilt from mid-bit samples taken on the 16x bit-time tick, so the echoed waveform has clean bit edges and a fixed one-bit delay. The transmitter and receiver engines, the FIFO and the baud generator live outside this block and are seen only through ports.

Top module: `uart_loop_router`

## Requirements
- R1: `mode` is decoded as 2'b00 normal, 2'b01 local loopback and 2'b10 remote loopback. Code 2'b11 behaves exactly like normal.
- R2: In normal mode the block passes signals straight through. `pin_txd` = `tx_sdo`, `rx_sdi` = `pin_rxd`, `tx_go` = `tx_en & (!cts_chk_en | pin_cts)`, `pin_rts` = `rts_en & rx_rts_req`, `rx_active` = `rx_en`, and `fifo_wr`, `err_par`, `err_frm` copy `rx_char_valid`, `rx_par_err`, `rx_frm_err`.
- R3: In local loopback `rx_sdi` equals `tx_sdo`, and `pin_rxd` has no effect on any output.
- R4: In local loopback `pin_txd` is held at 1.
- R5: In local loopback `tx_go` equals `tx_en` whatever `pin_cts` and `cts_chk_en` are, and `pin_rts` is 0 whatever `rts_en` is.
- R6: In local loopback `rx_active` is 1 even when `rx_en` is 0.
- R7: In remote loopback `pin_txd` echoes `pin_rxd` re-timed on `tick16`. The phase count restarts on each tick that sees a level change on `pin_rxd` and wraps every OVERSAMPLE ticks. The level is sampled when the count reaches OVERSAMPLE/2, and it is driven out from the next count-zero tick. The echo is therefore one bit time late, and it idles at 1.
- R8: In remote loopback `fifo_wr`, `err_par` and `err_frm` stay 0.
- R9: In remote loopback `tx_go` is 0, and `pin_cts` has no effect on the echo.
- R10: In any cycle where `mode` differs from its value in the previous cycle (reset value 2'b00), `pin_txd` is 1. The new mode takes effect in that same cycle on every other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Channel mode select |
| tick16 | input | 1 | One-cycle pulse, OVERSAMPLE per bit time |
| tx_sdo | input | 1 | Serial output of the transmitter engine |
| tx_en | input | 1 | Transmitter enable setting |
| cts_chk_en | input | 1 | Enables clear-to-send gating of the transmitter |
| pin_cts | input | 1 | Clear-to-send pin, 1 means clear |
| pin_rxd | input | 1 | External serial data-in pin |
| rx_en | input | 1 | Receiver enable setting |
| rts_en | input | 1 | Enables request-to-send output from the receiver |
| rx_rts_req | input | 1 | Receiver's request-to-send level |
| rx_char_valid | input | 1 | Receiver strobe: character complete |
| rx_par_err | input | 1 | Receiver parity error strobe |
| rx_frm_err | input | 1 | Receiver framing error strobe |
| pin_txd | output | 1 | External serial data-out pin |
| rx_sdi | output | 1 | Serial input to the receiver engine |
| tx_go | output | 1 | Transmitter is allowed to send |
| pin_rts | output | 1 | Request-to-send pin |
| rx_active | output | 1 | Receiver engine runs |
| fifo_wr | output | 1 | Write strobe into the receive FIFO |
| err_par | output | 1 | Parity error reported to status |
| err_frm | output | 1 | Framing error reported to status |

## Verification
The bench builds the block with the default OVERSAMPLE of 16. It drives `tick16` once every four clocks, so one bit spans 64 clocks. That makes a full echoed bit pattern, including runs of equal bits that depend on the phase wrap rather than on edges, reachable in a few thousand cycles. Random settings in all four mode codes, together with rapid mode switching, cover the pass-through overrides and the forced-high cycle after every mode change.

// File: rtl/uart_loop_router.sv
module uart_loop_router #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tick16,
  input  logic       tx_sdo,
  input  logic       tx_en,
  input  logic       cts_chk_en,
  input  logic       pin_cts,
  input  logic       pin_rxd,
  input  logic       rx_en,
  input  logic       rts_en,
  input  logic       rx_rts_req,
  input  logic       rx_char_valid,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  output logic       pin_txd,
  output logic       rx_sdi,
  output logic       tx_go,
  output logic       pin_rts,
  output logic       rx_active,
  output logic       fifo_wr,
  output logic       err_par,
  output logic       err_frm
);
  localparam int unsigned PW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int unsigned MID  = OVERSAMPLE / 2;
  localparam int unsigned LAST = OVERSAMPLE - 1;
  localparam logic [1:0]  M_LOCAL  = 2'b01;
  localparam logic [1:0]  M_REMOTE = 2'b10;

  logic          is_local, is_remote, mode_chg, run;
  logic [1:0]    mode_q;
  logic [PW-1:0] ph_q, ph_n;
  logic          prev_q, hold_q, echo_q, rx_edge;

  assign is_local  = (mode == M_LOCAL);
  assign is_remote = (mode == M_REMOTE);
  assign mode_chg  = (mode != mode_q);
  assign run       = is_remote & ~mode_chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= 2'b00;
    else        mode_q <= mode;

  assign rx_edge = (pin_rxd != prev_q);
  assign ph_n    = (rx_edge || ph_q == PW'(LAST)) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0; prev_q <= 1'b1; hold_q <= 1'b1; echo_q <= 1'b1;
    end else if (!run) begin
      ph_q <= '0; prev_q <= 1'b1; hold_q <= 1'b1; echo_q <= 1'b1;
    end else if (tick16) begin
      ph_q   <= ph_n;
      prev_q <= pin_rxd;
      if (ph_n == PW'(MID)) hold_q <= pin_rxd;
      if (ph_n == '0)       echo_q <= hold_q;
    end
  end

  assign pin_txd   = mode_chg | is_local | (is_remote ? echo_q : tx_sdo);
  assign rx_sdi    = is_local ? tx_sdo : pin_rxd;
  assign tx_go     = is_remote ? 1'b0 :
                     is_local  ? tx_en : (tx_en & (~cts_chk_en | pin_cts));
  assign pin_rts   = ~is_local & rts_en & rx_rts_req;
  assign rx_active = is_local | rx_en;
  assign fifo_wr   = ~is_remote & rx_char_valid;
  assign err_par   = ~is_remote & rx_par_err;
  assign err_frm   = ~is_remote & rx_frm_err;
endmodule

// File: rtl/uart_loop_router_chk.sv
module uart_loop_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tick16,
  input logic       tx_sdo,
  input logic       tx_en,
  input logic       pin_txd,
  input logic       rx_sdi,
  input logic       tx_go,
  input logic       pin_rts,
  input logic       rx_active,
  input logic       fifo_wr,
  input logic       err_par,
  input logic       err_frm
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;

  assert_local_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (rx_sdi == tx_sdo));
  assert_local_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> pin_txd);
  assert_local_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!pin_rts && tx_go == tx_en));
  assert_local_rxon_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> rx_active);
  assert_echo_held_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (mode == 2'b10 && $past(mode) == 2'b10 && !$past(tick16)) |-> $stable(pin_txd));
  assert_remote_nodeliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!fifo_wr && !err_par && !err_frm));
  assert_remote_txoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> !tx_go);
  assert_change_idle_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (mode != $past(mode)) |-> pin_txd);
endmodule

bind uart_loop_router uart_loop_router_chk u_chk (.*);

// File: tb/tb_uart_loop_router.sv
`timescale 1ns/100ps
module tb_uart_loop_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic tick16 = 1'b0, tx_sdo = 1'b1, tx_en = 1'b0, cts_chk_en = 1'b0, pin_cts = 1'b0;
  logic pin_rxd = 1'b1, rx_en = 1'b0, rts_en = 1'b0, rx_rts_req = 1'b0;
  logic rx_char_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic pin_txd, rx_sdi, tx_go, pin_rts, rx_active, fifo_wr, err_par, err_frm;

  int checks = 0, errors = 0, cyc = 0, tc = 0;
  bit chk_on = 0, rand_on = 0, rxd_rand = 1;
  logic [1:0] mq;

  uart_loop_router dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mq <= 2'b00;
    else        mq <= mode;

  always @(posedge clk) begin
    #1;
    tc = (tc + 1) % 4;
    tick16 = (tc == 0);
    if (rand_on) begin
      tx_sdo = 1'($urandom); tx_en = 1'($urandom); cts_chk_en = 1'($urandom);
      pin_cts = 1'($urandom); rx_en = 1'($urandom); rts_en = 1'($urandom);
      rx_rts_req = 1'($urandom); rx_char_valid = 1'($urandom);
      rx_par_err = 1'($urandom); rx_frm_err = 1'($urandom);
      if (rxd_rand) pin_rxd = 1'($urandom);
    end
  end

  // Reference model, evaluated mid-cycle on every clock
  always @(posedge clk) begin
    #4;
    if (rst_n && chk_on) begin
      bit chg, loc, rem;
      string nt;
      chg = (mode != mq);
      loc = (mode == 2'b01);
      rem = (mode == 2'b10);
      nt  = (mode == 2'b11) ? "R1" : "R2";
      if (chg)      check(pin_txd == 1'b1, "R10 pin_txd", pin_txd, 1);
      else if (loc) check(pin_txd == 1'b1, "R4 pin_txd", pin_txd, 1);
      else if (!rem) check(pin_txd == tx_sdo, {nt, " pin_txd"}, pin_txd, tx_sdo);
      if (loc) begin
        check(rx_sdi == tx_sdo, "R3 rx_sdi", rx_sdi, tx_sdo);
        check(tx_go == tx_en, "R5 tx_go", tx_go, tx_en);
        check(pin_rts == 1'b0, "R5 pin_rts", pin_rts, 0);
        check(rx_active == 1'b1, "R6 rx_active", rx_active, 1);
        check(fifo_wr == rx_char_valid, "R3 fifo_wr", fifo_wr, rx_char_valid);
      end else if (rem) begin
        check(tx_go == 1'b0, "R9 tx_go", tx_go, 0);
        check({fifo_wr, err_par, err_frm} == 3'b000, "R8 strobes", {fifo_wr, err_par, err_frm}, 0);
        check(rx_sdi == pin_rxd, "R7 rx_sdi", rx_sdi, pin_rxd);
        check(pin_rts == (rts_en & rx_rts_req), "R7 pin_rts", pin_rts, rts_en & rx_rts_req);
      end else begin
        check(rx_sdi == pin_rxd, {nt, " rx_sdi"}, rx_sdi, pin_rxd);
        check(tx_go == (tx_en & (!cts_chk_en | pin_cts)), {nt, " tx_go"}, tx_go,
              tx_en & (!cts_chk_en | pin_cts));
        check(pin_rts == (rts_en & rx_rts_req), {nt, " pin_rts"}, pin_rts, rts_en & rx_rts_req);
        check(rx_active == rx_en, {nt, " rx_active"}, rx_active, rx_en);
        check({fifo_wr, err_par, err_frm} == {rx_char_valid, rx_par_err, rx_frm_err},
              {nt, " strobes"}, {fifo_wr, err_par, err_frm},
              {rx_char_valid, rx_par_err, rx_frm_err});
      end
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (!tick16);
  endtask

  task automatic send_bit(input logic v, input logic exp_prev);
    #1 pin_rxd = v;
    for (int i = 1; i <= 16; i++) begin
      wait_tick();
      if (i == 8) begin
        #3 check(pin_txd == exp_prev, "R7 echo", pin_txd, exp_prev);
      end
    end
  endtask

  initial begin
    logic [15:0] pat;
    logic prev;
    mode = 2'b10;
    repeat (3) @(posedge clk);
    #3 check(pin_txd == 1'b1, "R10 reset idle", pin_txd, 1);
    @(posedge clk); #1 rst_n = 1'b1; mode = 2'b00;
    chk_on = 1; rand_on = 1;
    for (int m = 0; m < 4; m++) begin
      @(posedge clk); #1 mode = 2'(m);
      repeat (200) @(posedge clk);
    end
    @(posedge clk); #1 mode = 2'b01;
    repeat (300) @(posedge clk);
    // remote echo
    rxd_rand = 0;
    @(posedge clk); #1 pin_rxd = 1'b1; mode = 2'b10;
    repeat (20) wait_tick();
    pat = 16'b1110_0110_1001_0110;
    prev = 1'b1;
    send_bit(1'b0, prev); prev = 1'b0;
    for (int b = 0; b < 16; b++) begin
      send_bit(pat[b], prev);
      prev = pat[b];
    end
    send_bit(1'b1, prev); prev = 1'b1;
    send_bit(1'b1, prev);
    send_bit(1'b1, 1'b1);
    // rapid switching
    rxd_rand = 1;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1 mode = 2'($urandom);
      repeat ($urandom_range(0, 3)) @(posedge clk);
    end
    @(posedge clk); #1 mode = 2'b00;
    repeat (10) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule